// File: doc/BRIEF.md
# CAN Transmit Buffer Abort Controller

This block holds the status and control bits of three CAN transmit message buffers and decides when a software request to withdraw a scheduled buffer may take effect. Each buffer has an empty flag, an abort-request bit, an abort-acknowledge bit and an interrupt enable. A CPU register port reads and writes these bits through two 8-bit registers. A status register holds the empty flags and the acknowledges. A control register holds the abort requests and the interrupt enables.

The transmit engine reports which buffer is on the bus and pulses a completion strobe when that buffer's frame has been sent. A pending abort is granted only on a cycle when its buffer is not the one on the bus. A granted abort marks the buffer empty and sets its acknowledge. A completed frame marks the buffer empty and leaves the acknowledge clear. A single interrupt output is raised while any buffer is empty and enabled. The block does no framing, no arbitration and no buffer storage, and it does not pick the next buffer to send.

Top module: `can_txab_top`

## Requirements
- R1: After reset (`rst_n` low) the status register (address 0) reads 0x07: empty flags in bits 2:0 all 1 and acknowledges in bits 6:4 all 0. The control register (address 1) reads 0x00, and `tx_irq` is 0.
- R2: A CPU write of 1 to status bit i (i = 0..2) clears buffer i's empty flag at the next clock edge. A write of 0 leaves the flag unchanged.
- R3: A CPU write of 1 to control bit 4+i sets buffer i's abort request only if its empty flag is 0. The write is ignored when the flag is 1. Writing 0 never clears a request.
- R4: A pending request on a buffer that is not on the bus (`tx_active` low, or `tx_buf` different from that buffer) is granted at the next clock edge. The grant sets the empty flag, sets the acknowledge (status bit 4+i) and clears the request.
- R5: While a buffer is on the bus and has no completion, its pending request stays set and its empty flag stays 0.
- R6: `tx_done` together with `tx_active` completes buffer `tx_buf`. At the next edge its empty flag sets, its acknowledge stays 0 and its request clears. Completion takes priority over a pending abort.
- R7: Clearing a buffer's empty flag through R2 also clears its acknowledge and request in the same cycle.
- R8: `tx_irq` is 1 exactly when some buffer has both its empty flag and its enable (control bits 2:0, read/write) at 1.
- R9: While `soft_rst` is high, the empty flags are held at 1 and the acknowledges and requests at 0, and CPU writes to the status register have no effect. Interrupt enables keep their values.
- R10: Bits 7 and 3 of both registers always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| soft_rst | input | 1 | Holds the status state at its reset value |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 1 | 0 selects the status register, 1 selects the control register |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the selected register (combinational) |
| tx_active | input | 1 | Transmit engine has a buffer on the bus |
| tx_buf | input | 2 | Index of the buffer on the bus |
| tx_done | input | 1 | Frame of buffer `tx_buf` completed successfully |
| tx_irq | output | 1 | Combined transmit interrupt |

## Verification
A wrong grant decision shows in the status register on the very next read after the deciding edge. If the abort was granted too early, the empty and acknowledge bits of a buffer on the bus appear set while the request bit is gone. If the grant was withheld, a request that should have cleared stays visible in the control register. A request or acknowledge left standing after the flag changes shows as a set bit beside a flag that no longer matches it. Any error in an empty flag reaches `tx_irq` in the same cycle when that buffer's enable is set.

// File: rtl/can_txab_pkg.sv
package can_txab_pkg;
  localparam int NBUF      = 3;
  localparam int REG_W     = 8;
  localparam int HI_BASE   = 4;
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
endpackage

// File: rtl/can_txab_slot.sv
module can_txab_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic sched,
  input  logic set_req,
  input  logic on_bus,
  input  logic done,
  output logic empty,
  output logic ack,
  output logic req
);
  logic empty_d, ack_d, req_d;

  always_comb begin
    empty_d = empty;
    ack_d   = ack;
    req_d   = req;
    if (soft_rst) begin
      empty_d = 1'b1;
      ack_d   = 1'b0;
      req_d   = 1'b0;
    end else if (done) begin
      empty_d = 1'b1;
      ack_d   = 1'b0;
      req_d   = 1'b0;
    end else if (req && !empty && !on_bus) begin
      empty_d = 1'b1;
      ack_d   = 1'b1;
      req_d   = 1'b0;
    end else if (sched && empty) begin
      empty_d = 1'b0;
      ack_d   = 1'b0;
      req_d   = 1'b0;
    end else if (set_req && !empty) begin
      req_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty <= 1'b1;
      ack   <= 1'b0;
      req   <= 1'b0;
    end else begin
      empty <= empty_d;
      ack   <= ack_d;
      req   <= req_d;
    end
  end
endmodule

// File: rtl/can_txab_regif.sv
module can_txab_regif
  import can_txab_pkg::*;
#(
  parameter int N = NBUF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cpu_wr,
  input  logic             cpu_addr,
  input  logic [REG_W-1:0] cpu_wdata,
  input  logic [N-1:0]     empty,
  input  logic [N-1:0]     ack,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     sched,
  output logic [N-1:0]     set_req,
  output logic [N-1:0]     ie,
  output logic [REG_W-1:0] cpu_rdata
);
  logic             wr_stat, wr_ctrl, ie_en;
  logic [N-1:0]     ie_d;
  logic [REG_W-1:0] stat_word, ctrl_word;

  assign wr_stat = cpu_wr && (cpu_addr == ADDR_STAT) && !soft_rst;
  assign wr_ctrl = cpu_wr && (cpu_addr == ADDR_CTRL);
  assign ie_en   = wr_ctrl;
  assign ie_d    = cpu_wdata[N-1:0];

  always_comb begin
    sched     = '0;
    set_req   = '0;
    stat_word = '0;
    ctrl_word = '0;
    for (int i = 0; i < N; i++) begin
      sched[i]             = wr_stat && cpu_wdata[i];
      set_req[i]           = wr_ctrl && cpu_wdata[HI_BASE+i];
      stat_word[i]         = empty[i];
      stat_word[HI_BASE+i] = ack[i];
      ctrl_word[i]         = ie[i];
      ctrl_word[HI_BASE+i] = req[i];
    end
  end

  assign cpu_rdata = (cpu_addr == ADDR_CTRL) ? ctrl_word : stat_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie <= '0;
    end else if (ie_en) begin
      ie <= ie_d;
    end
  end
endmodule

// File: rtl/can_txab_top.sv
module can_txab_top
  import can_txab_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cpu_wr,
  input  logic             cpu_addr,
  input  logic [REG_W-1:0] cpu_wdata,
  output logic [REG_W-1:0] cpu_rdata,
  input  logic             tx_active,
  input  logic [1:0]       tx_buf,
  input  logic             tx_done,
  output logic             tx_irq
);
  logic [NBUF-1:0] empty, ack, req, ie, sched, set_req;

  can_txab_regif #(.N(NBUF)) u_regif (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .empty(empty), .ack(ack), .req(req),
    .sched(sched), .set_req(set_req), .ie(ie), .cpu_rdata(cpu_rdata)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_slot
    logic on_bus;
    assign on_bus = tx_active && (tx_buf == 2'(g));
    can_txab_slot u_slot (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .sched(sched[g]), .set_req(set_req[g]),
      .on_bus(on_bus), .done(on_bus && tx_done),
      .empty(empty[g]), .ack(ack[g]), .req(req[g])
    );
  end

  assign tx_irq = |(empty & ie);
endmodule

// File: rtl/can_txab_chk.sv
module can_txab_chk
  import can_txab_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            soft_rst,
  input logic            tx_active,
  input logic [1:0]      tx_buf,
  input logic            tx_done,
  input logic [NBUF-1:0] empty,
  input logic [NBUF-1:0] ack,
  input logic [NBUF-1:0] req
);
  for (genvar g = 0; g < NBUF; g++) begin : g_chk
    // R4
    grant_sets_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req[g] && !empty[g] && !soft_rst && !(tx_active && tx_buf == 2'(g)))
      |=> (empty[g] && ack[g] && !req[g]));
    // R5
    busy_holds_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req[g] && !soft_rst && !tx_done && tx_active && tx_buf == 2'(g))
      |=> (req[g] && !empty[g]));
    // R6
    done_frees_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && tx_done && tx_active && tx_buf == 2'(g))
      |=> (empty[g] && !ack[g] && !req[g]));
    // R3
    req_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req[g] |-> !empty[g]);
    // R7
    ack_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack[g] |-> empty[g]);
  end
  // R9
  soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (&empty && ack == '0 && req == '0));
endmodule

bind can_txab_top can_txab_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
  .tx_active(tx_active), .tx_buf(tx_buf), .tx_done(tx_done),
  .empty(empty), .ack(ack), .req(req)
);

// File: tb/sim_can_txab_top.sv
module sim_can_txab_top;
  logic       clk = 1'b0;
  logic       rst_n, soft_rst, cpu_wr, cpu_addr, tx_active, tx_done;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic [1:0] tx_buf;
  logic       tx_irq;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  can_txab_top u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .tx_active(tx_active), .tx_buf(tx_buf), .tx_done(tx_done), .tx_irq(tx_irq)
  );

  typedef struct packed {
    logic [7:0] rq;
    logic       srst;
    logic       wr;
    logic       addr;
    logic [7:0] wd;
    logic       act;
    logic [1:0] idx;
    logic       done;
    logic [7:0] e_stat;
    logic [7:0] e_ctrl;
    logic       e_irq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [0:NV-1] = '{
    '{8'd1, 1'b0,1'b0,1'b0,8'h00, 1'b0,2'd0,1'b0, 8'h07,8'h00,1'b0}, // R1 idle
    '{8'd8, 1'b0,1'b1,1'b1,8'h07, 1'b0,2'd0,1'b0, 8'h07,8'h07,1'b1}, // R8 enables on
    '{8'd2, 1'b0,1'b1,1'b0,8'h00, 1'b0,2'd0,1'b0, 8'h07,8'h07,1'b1}, // R2 zero write
    '{8'd3, 1'b0,1'b1,1'b1,8'h17, 1'b0,2'd0,1'b0, 8'h07,8'h07,1'b1}, // R3 req on empty
    '{8'd2, 1'b0,1'b1,1'b0,8'h03, 1'b0,2'd0,1'b0, 8'h04,8'h07,1'b1}, // R2 schedule 0,1
    '{8'd8, 1'b0,1'b1,1'b1,8'h00, 1'b0,2'd0,1'b0, 8'h04,8'h00,1'b0}, // R8 enables off
    '{8'd3, 1'b0,1'b1,1'b1,8'h30, 1'b1,2'd0,1'b0, 8'h04,8'h30,1'b0}, // R3 req 0,1
    '{8'd4, 1'b0,1'b0,1'b0,8'h00, 1'b1,2'd0,1'b0, 8'h26,8'h10,1'b0}, // R4 buf1, R5 buf0
    '{8'd5, 1'b0,1'b0,1'b0,8'h00, 1'b1,2'd0,1'b0, 8'h26,8'h10,1'b0}, // R5 still pending
    '{8'd3, 1'b0,1'b1,1'b1,8'h00, 1'b1,2'd0,1'b0, 8'h26,8'h10,1'b0}, // R3 cannot clear
    '{8'd6, 1'b0,1'b0,1'b0,8'h00, 1'b1,2'd0,1'b1, 8'h27,8'h00,1'b0}, // R6 done wins
    '{8'd7, 1'b0,1'b1,1'b0,8'h02, 1'b0,2'd0,1'b0, 8'h05,8'h00,1'b0}, // R7 ack cleared
    '{8'd3, 1'b0,1'b1,1'b1,8'h24, 1'b0,2'd0,1'b0, 8'h05,8'h24,1'b1}, // R3 req buf1
    '{8'd4, 1'b0,1'b0,1'b0,8'h00, 1'b0,2'd0,1'b0, 8'h27,8'h04,1'b1}, // R4 idle bus
    '{8'd10,1'b0,1'b1,1'b1,8'h88, 1'b0,2'd0,1'b0, 8'h27,8'h00,1'b0}, // R10 dead bits
    '{8'd7, 1'b0,1'b1,1'b0,8'h07, 1'b1,2'd2,1'b0, 8'h00,8'h00,1'b0}, // R7 schedule all
    '{8'd3, 1'b0,1'b1,1'b1,8'h41, 1'b1,2'd2,1'b0, 8'h00,8'h41,1'b0}, // R3 req buf2
    '{8'd5, 1'b0,1'b0,1'b0,8'h00, 1'b1,2'd2,1'b0, 8'h00,8'h41,1'b0}, // R5 buf2 busy
    '{8'd9, 1'b1,1'b0,1'b0,8'h00, 1'b1,2'd2,1'b0, 8'h07,8'h01,1'b1}, // R9 soft reset
    '{8'd9, 1'b1,1'b1,1'b0,8'h07, 1'b1,2'd2,1'b0, 8'h07,8'h01,1'b1}, // R9 write held
    '{8'd9, 1'b0,1'b0,1'b0,8'h00, 1'b0,2'd0,1'b0, 8'h07,8'h01,1'b1}  // R9 released
  };

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic read_all(input string tag, input logic [7:0] es,
                          input logic [7:0] ec, input logic ei);
    cpu_addr = 1'b0; #1;
    chk8({tag, " status"}, cpu_rdata, es);
    cpu_addr = 1'b1; #1;
    chk8({tag, " control"}, cpu_rdata, ec);
    chk8({tag, " irq"}, {7'd0, tx_irq}, {7'd0, ei});
  endtask

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; cpu_wr = 1'b0; cpu_addr = 1'b0;
    cpu_wdata = '0; tx_active = 1'b0; tx_buf = '0; tx_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    read_all("R1 reset", 8'h07, 8'h00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NV; k++) begin
      soft_rst  = TBL[k].srst;
      cpu_wr    = TBL[k].wr;
      cpu_addr  = TBL[k].addr;
      cpu_wdata = TBL[k].wd;
      tx_active = TBL[k].act;
      tx_buf    = TBL[k].idx;
      tx_done   = TBL[k].done;
      @(posedge clk); #1;
      cpu_wr = 1'b0; tx_done = 1'b0; soft_rst = 1'b0;
      read_all($sformatf("R%0d row %0d", TBL[k].rq, k),
               TBL[k].e_stat, TBL[k].e_ctrl, TBL[k].e_irq);
      @(negedge clk);
    end
    // R6: completion of an idle buffer leaves acknowledge clear
    cpu_wr = 1'b1; cpu_addr = 1'b0; cpu_wdata = 8'h01;
    @(posedge clk); #1; cpu_wr = 1'b0;
    read_all("R2 sched buf0", 8'h06, 8'h01, 1'b0);
    @(negedge clk);
    tx_active = 1'b1; tx_buf = 2'd0; tx_done = 1'b1;
    @(posedge clk); #1; tx_done = 1'b0; tx_active = 1'b0;
    read_all("R6 done buf0", 8'h07, 8'h01, 1'b1);
    @(negedge clk);
    // R1: asynchronous reset mid-run
    rst_n = 1'b0; #2;
    read_all("R1 async reset", 8'h07, 8'h00, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule